// File: doc/BRIEF.md
# Fault-Test Kernel Sequencer

This controller runs one diagnostic test on a microprogrammed processor. The test occupies fourteen consecutive 32-bit words of storage starting at a byte address given with the start pulse. The sequencer first copies eleven of those words onto a scan bus that preloads processor registers. It then reads the twelfth word, a linkage control word, into a storage data register. From that word it takes the starting control-store address, a 3-bit sequence counter and an I/O mode flag, and it sets the supervisory flags to fixed values.

Next the sequencer advances the processor one control-store word per cycle. Each step bumps the sequence counter, until the counter reaches seven. At seven the control-store address is forced to the scan-out entry. In the scan-out phase the thirteenth and fourteenth test words are saved to two fixed storage locations. Fourteen register words are then read over the scan bus and written to a dump area. A one-cycle done pulse hands control to the compare stage.

Storage reads have one cycle of latency, and addresses are byte addresses in steps of four. The control store supplies the next-address field of the word currently addressed.

Top module: `ftk_sequencer`

## Requirements
- R1: After `start` in idle, eleven storage words are read from `test_base`, `test_base+4`, … `test_base+40`. Word i (0-based) appears on `scan_in_data` with `scan_in_valid` high and `scan_sel = i`.
- R2: The read address changes only by advancing 4 bytes per word. The linkage word is read at `test_base+44`, and the two saved words are read at `test_base+48` and `test_base+52`.
- R3: The linkage word is decoded with bit 0 as the most significant bit of the 32-bit word. Bits 0-2 ([31:29]) load the sequence counter, bit 7 ([24]) gives the I/O mode flag, and bits 19-30 ([12:1]) give the 12-bit control-store address. All other bits have no effect.
- R4: Executing the linkage word sets `supv_flag` to 1 and clears `prog_scan_flag` and `sup_en_flag`, whatever bits 4, 5 and 6 ([27], [26], [25]) hold. `io_mode_flag` copies bit 7.
- R5: Each clock-advance step with a nonzero control-store address pulses `cs_step` for one cycle while `cs_addr` shows the word being executed. In the next cycle `cs_addr` takes `cs_next` and `seq_cnt` is one higher.
- R6: When `seq_cnt` equals 7, no further step occurs, `seq_cnt` never wraps, and `cs_addr` is forced to 0x2C0. A linkage word that loads 7 gives zero steps.
- R7: Zero-cycle test: while `cs_addr` is 0 during clock advance, `cs_step` stays low and `cs_addr` stays 0. The counter still advances to 7.
- R8: In scan-out, test word 13 is written to byte address 0x80 and test word 14 to byte address 0x84.
- R9: Fourteen register words are then written. Word k is taken from `scan_out_data` while `scan_sel = k` and is stored at `DUMP_BASE + 4k` (default 0x100).
- R10: `done` is high for exactly one cycle after the last dump write. `start` has no effect until `done` has occurred.
- R11: Synchronous active-low reset clears `done`, the storage strobes, `cs_step`, `seq_cnt`, `cs_addr` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test (sampled only when idle) |
| test_base | input | ADDR_W | Byte address of test word 1 |
| mem_rd_en | output | 1 | Storage read strobe |
| mem_rd_addr | output | ADDR_W | Storage read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Storage write strobe |
| mem_wr_addr | output | ADDR_W | Storage write byte address |
| mem_wr_data | output | 32 | Storage write data |
| scan_in_valid | output | 1 | Scan-in word valid |
| scan_sel | output | SEL_W | Scan destination or source index |
| scan_in_data | output | 32 | Scan-in word |
| scan_out_data | input | 32 | Register word selected by `scan_sel` |
| cs_addr | output | 12 | Current control-store address |
| cs_next | input | 12 | Next-address field of the addressed control-store word |
| cs_step | output | 1 | Execute the addressed control-store word this cycle |
| seq_cnt | output | 3 | Sequence counter |
| io_mode_flag | output | 1 | I/O mode flag |
| supv_flag | output | 1 | Supervisory flag |
| prog_scan_flag | output | 1 | Progressive-scan flag |
| sup_en_flag | output | 1 | Supervisory-enable-storage flag |
| done | output | 1 | Test sequence finished (one cycle) |

## Verification
A misdecoded linkage word shows up as a wrong `cs_addr` on the first `cs_step` or a wrong `io_mode_flag`. Both are visible within three cycles of the linkage read. A counter that mis-steps changes how many `cs_step` pulses occur before the forced 0x2C0. An address register that drifts places scan-in values on the wrong `scan_sel` indices, or puts the saved words at 0x80/0x84 from the wrong locations. Both can be read in storage right after `done`. A phase machine that loses its place shows as a missing `done`, a doubled `done`, or a restart on a `start` pulse given mid-test.

// File: rtl/ftk_pkg.sv
// Package: shared widths, constants, phase encoding and the decoded
// linkage-word record used by the fault-test kernel sequencer.
// Assumes 32-bit storage words with bit 0 the most significant bit.
package ftk_pkg;
    localparam int WORD_W = 32;
    localparam int CS_AW  = 12;
    localparam int SEQ_W  = 3;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [CS_AW-1:0] csa_t;

    localparam seq_t SEQ_STOP = 3'd7;
    localparam csa_t SO_ENTRY = 12'h2C0;

    // Decoded linkage control word fields that drive state.
    typedef struct packed {
        seq_t seq;
        logic io_mode;
        csa_t cs_start;
    } lcw_t;

    typedef enum logic [3:0] {
        PH_IDLE, PH_SI_RD, PH_SI_CAP, PH_LCW_RD, PH_LCW_CAP, PH_LCW_EXE,
        PH_ADV, PH_SV_RD, PH_SV_WR, PH_DUMP, PH_FIN
    } phase_e;
endpackage

// File: rtl/ftk_lcw_decode.sv
// Linkage-word decoder: pure combinational field extraction.
// Assumes the word is numbered with bit 0 as the MSB. Bits that are forced
// rather than copied (supervisory flags) and reserved bits are dropped here.
module ftk_lcw_decode
    import ftk_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output lcw_t              fields
);
    localparam int SEQ_MSB = WORD_W - 1;        // bit 0
    localparam int IO_POS  = WORD_W - 1 - 7;    // bit 7
    localparam int CS_MSB  = WORD_W - 1 - 19;   // bits 19..30

    logic unused_bits;

    // Field extraction.
    always_comb begin
        fields.seq      = word[SEQ_MSB -: SEQ_W];
        fields.io_mode  = word[IO_POS];
        fields.cs_start = word[CS_MSB -: CS_AW];
    end

    // Bits with no function here.
    assign unused_bits = ^{word[SEQ_MSB-SEQ_W:IO_POS+1], word[IO_POS-1:CS_MSB+1],
                           word[CS_MSB-CS_AW:0]};
endmodule

// File: rtl/ftk_clock_adv.sv
// Clock-advance engine: holds the sequence counter and control-store address.
// On load takes the linkage fields. While enabled, executes one control-store
// word per cycle (skipped when the address is zero) and steps the counter.
// When the counter sits at the stop value it forces the scan-out entry and
// reports completion. Assumes load and enable are never high together.
module ftk_clock_adv
    import ftk_pkg::*;
#(
    parameter seq_t STOP  = SEQ_STOP,
    parameter csa_t ENTRY = SO_ENTRY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  seq_t load_seq,
    input  csa_t load_cs,
    input  logic adv_en,
    input  csa_t cs_next,
    output csa_t cs_addr,
    output seq_t seq_cnt,
    output logic cs_step,
    output logic adv_done
);
    logic at_stop;
    logic zero_word;

    assign at_stop   = (seq_cnt == STOP);
    assign zero_word = (cs_addr == '0);
    assign cs_step   = adv_en && !at_stop && !zero_word;
    assign adv_done  = adv_en && at_stop;

    // Counter and address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_cnt <= '0;
            cs_addr <= '0;
        end else if (load) begin
            seq_cnt <= load_seq;
            cs_addr <= load_cs;
        end else if (adv_en) begin
            if (at_stop) begin
                cs_addr <= ENTRY;
            end else begin
                seq_cnt <= seq_cnt + seq_t'(1);
                if (!zero_word) cs_addr <= cs_next;
            end
        end
    end
endmodule

// File: rtl/ftk_sequencer.sv
// Fault-test kernel sequencer top. Walks one test through scan-in, linkage
// fetch and execute, clock advance, save of two test words, register dump
// and a done pulse. Assumes storage reads return data one cycle after the
// strobe and that scan_out_data follows scan_sel combinationally.
module ftk_sequencer
    import ftk_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                N_SCAN_IN  = 11,
    parameter int                N_SCAN_OUT = 14,
    parameter int                SEL_W      = $clog2(N_SCAN_OUT),
    parameter logic [ADDR_W-1:0] SAVE_A     = 'h80,
    parameter logic [ADDR_W-1:0] SAVE_B     = 'h84,
    parameter logic [ADDR_W-1:0] DUMP_BASE  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] test_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              scan_in_valid,
    output logic [SEL_W-1:0]  scan_sel,
    output logic [WORD_W-1:0] scan_in_data,
    input  logic [WORD_W-1:0] scan_out_data,
    output logic [CS_AW-1:0]  cs_addr,
    input  logic [CS_AW-1:0]  cs_next,
    output logic              cs_step,
    output logic [SEQ_W-1:0]  seq_cnt,
    output logic              io_mode_flag,
    output logic              supv_flag,
    output logic              prog_scan_flag,
    output logic              sup_en_flag,
    output logic              done
);
    localparam logic [ADDR_W-1:0] WSTEP   = ADDR_W'(4);
    localparam logic [SEL_W-1:0]  LAST_SI = SEL_W'(N_SCAN_IN - 1);
    localparam logic [SEL_W-1:0]  LAST_SO = SEL_W'(N_SCAN_OUT - 1);

    phase_e              phase;
    logic [ADDR_W-1:0]   iar;
    logic [SEL_W-1:0]    idx;
    logic [WORD_W-1:0]   sdr;
    lcw_t                lcw;
    logic                adv_done;

    ftk_lcw_decode u_dec (
        .word   (sdr),
        .fields (lcw)
    );

    ftk_clock_adv u_adv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase == PH_LCW_EXE),
        .load_seq (lcw.seq),
        .load_cs  (lcw.cs_start),
        .adv_en   (phase == PH_ADV),
        .cs_next  (cs_next),
        .cs_addr  (cs_addr),
        .seq_cnt  (seq_cnt),
        .cs_step  (cs_step),
        .adv_done (adv_done)
    );

    // Phase machine, word address register, index and linkage-word flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase          <= PH_IDLE;
            iar            <= '0;
            idx            <= '0;
            sdr            <= '0;
            io_mode_flag   <= 1'b0;
            supv_flag      <= 1'b0;
            prog_scan_flag <= 1'b0;
            sup_en_flag    <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    iar   <= test_base;
                    idx   <= '0;
                    phase <= PH_SI_RD;
                end
                PH_SI_RD: phase <= PH_SI_CAP;
                PH_SI_CAP: begin
                    iar <= iar + WSTEP;
                    if (idx == LAST_SI) begin
                        idx   <= '0;
                        phase <= PH_LCW_RD;
                    end else begin
                        idx   <= idx + SEL_W'(1);
                        phase <= PH_SI_RD;
                    end
                end
                PH_LCW_RD: phase <= PH_LCW_CAP;
                PH_LCW_CAP: begin
                    sdr   <= mem_rd_data;
                    iar   <= iar + WSTEP;
                    phase <= PH_LCW_EXE;
                end
                PH_LCW_EXE: begin
                    io_mode_flag   <= lcw.io_mode;
                    supv_flag      <= 1'b1;
                    prog_scan_flag <= 1'b0;
                    sup_en_flag    <= 1'b0;
                    phase          <= PH_ADV;
                end
                PH_ADV: if (adv_done) phase <= PH_SV_RD;
                PH_SV_RD: phase <= PH_SV_WR;
                PH_SV_WR: begin
                    iar <= iar + WSTEP;
                    if (idx != '0) begin
                        idx   <= '0;
                        phase <= PH_DUMP;
                    end else begin
                        idx   <= SEL_W'(1);
                        phase <= PH_SV_RD;
                    end
                end
                PH_DUMP: begin
                    if (idx == LAST_SO) begin
                        idx   <= '0;
                        phase <= PH_FIN;
                    end else begin
                        idx <= idx + SEL_W'(1);
                    end
                end
                PH_FIN:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Storage and scan strobes decoded from the phase.
    always_comb begin
        mem_rd_en     = (phase == PH_SI_RD) || (phase == PH_LCW_RD) || (phase == PH_SV_RD);
        mem_rd_addr   = iar;
        scan_in_valid = (phase == PH_SI_CAP);
        scan_in_data  = mem_rd_data;
        scan_sel      = idx;
        mem_wr_en     = (phase == PH_SV_WR) || (phase == PH_DUMP);
        mem_wr_addr   = '0;
        mem_wr_data   = '0;
        if (phase == PH_SV_WR) begin
            mem_wr_addr = (idx == '0) ? SAVE_A : SAVE_B;
            mem_wr_data = mem_rd_data;
        end else if (phase == PH_DUMP) begin
            mem_wr_addr = DUMP_BASE + (ADDR_W'(idx) << 2);
            mem_wr_data = scan_out_data;
        end
        done = (phase == PH_FIN);
    end
endmodule

// File: rtl/ftk_sequencer_chk.sv
// Checker for ftk_sequencer: temporal properties over its ports, bound below.
module ftk_sequencer_chk
    import ftk_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                N_SCAN_IN = 11,
    parameter int                SEL_W     = 4,
    parameter logic [ADDR_W-1:0] SAVE_A    = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_in_valid,
    input logic [SEL_W-1:0]  scan_sel,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              cs_step,
    input logic [CS_AW-1:0]  cs_addr,
    input logic [CS_AW-1:0]  cs_next,
    input logic [SEQ_W-1:0]  seq_cnt,
    input logic              done,
    input logic              supv_flag,
    input logic              prog_scan_flag,
    input logic              sup_en_flag
);
    p_scan_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        scan_in_valid |-> (32'(scan_sel) < N_SCAN_IN) && !mem_wr_en);

    p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_step |=> (seq_cnt == $past(seq_cnt) + 3'd1) && (cs_addr == $past(cs_next)));

    p_no_step_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cnt == SEQ_STOP) |-> !cs_step);

    p_zero_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_step |-> (cs_addr != '0));

    p_save_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_wr_addr == SAVE_A) |-> $past(mem_rd_en));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> supv_flag && !prog_scan_flag && !sup_en_flag
                 && (seq_cnt == SEQ_STOP) && (cs_addr == SO_ENTRY));
endmodule

bind ftk_sequencer ftk_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .N_SCAN_IN (N_SCAN_IN),
    .SEL_W     (SEL_W),
    .SAVE_A    (SAVE_A)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_in_valid  (scan_in_valid),
    .scan_sel       (scan_sel),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .mem_wr_addr    (mem_wr_addr),
    .cs_step        (cs_step),
    .cs_addr        (cs_addr),
    .cs_next        (cs_next),
    .seq_cnt        (seq_cnt),
    .done           (done),
    .supv_flag      (supv_flag),
    .prog_scan_flag (prog_scan_flag),
    .sup_en_flag    (sup_en_flag)
);

// File: tb/ftk_sequencer_tb_top.sv
// Directed bench for ftk_sequencer: storage, scan and control-store models.
module ftk_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] test_base = '0;
    logic        mem_rd_en, mem_wr_en, scan_in_valid, cs_step, done;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] mem_wr_data, scan_in_data, scan_out_data;
    logic [3:0]  scan_sel;
    logic [11:0] cs_addr, cs_next;
    logic [2:0]  seq_cnt;
    logic        io_mode_flag, supv_flag, prog_scan_flag, sup_en_flag;

    int n_pass = 0, n_total = 0;
    logic [7:0]  tag = 8'h00;
    logic [31:0] mem [0:127];
    logic [31:0] sreg [0:15];
    logic [11:0] step_log [0:7];
    int step_cnt = 0, done_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    ftk_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .test_base(test_base),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .scan_in_valid(scan_in_valid), .scan_sel(scan_sel), .scan_in_data(scan_in_data),
        .scan_out_data(scan_out_data), .cs_addr(cs_addr), .cs_next(cs_next),
        .cs_step(cs_step), .seq_cnt(seq_cnt), .io_mode_flag(io_mode_flag),
        .supv_flag(supv_flag), .prog_scan_flag(prog_scan_flag),
        .sup_en_flag(sup_en_flag), .done(done)
    );

    assign scan_out_data = {8'hC3, tag, 12'h000, scan_sel};
    assign cs_next       = cs_addr + 12'd3;

    // Storage, scan-register and event recorders.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[8:2]];
        if (mem_wr_en) mem[mem_wr_addr[8:2]] <= mem_wr_data;
        if (scan_in_valid) sreg[scan_sel] <= scan_in_data;
        if (cs_step) begin
            step_log[step_cnt % 8] <= cs_addr;
            step_cnt <= step_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    function automatic logic [31:0] mk_lcw(input logic [2:0] s, input logic io,
                                           input logic [11:0] cs, input bit noise);
        logic [31:0] w = '0;
        w[31:29] = s;
        w[24]    = io;
        w[12:1]  = cs;
        if (noise) begin
            w[27] = 1'b1; w[26] = 1'b1; w[28] = 1'b1; w[13] = 1'b1; w[0] = 1'b1;
        end else begin
            w[25] = 1'b1;
        end
        return w;
    endfunction

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 0 && mem_rd_en == 0 && mem_wr_en == 0, "R11 strobes", {done, mem_rd_en, mem_wr_en}, 0);
        chk(cs_step == 0 && seq_cnt == 0 && cs_addr == 0, "R11 counter/address", {cs_step, seq_cnt, cs_addr}, 0);
        chk({io_mode_flag, supv_flag, prog_scan_flag, sup_en_flag} == 0, "R11 flags",
            {io_mode_flag, supv_flag, prog_scan_flag, sup_en_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full test: load storage, run, check every phase's outcome.
    task automatic run_test(input logic [15:0] base, input logic [2:0] s0, input logic [11:0] cs0,
                            input logic io, input bit noise, input logic [7:0] t, input bit busy_starts);
        int st0, dn0, w0, exp_steps, wait_n;
        bit ok;
        tag = t;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        w0 = base >> 2;
        for (int i = 0; i < 11; i++) mem[w0 + i] = {t, 8'(i), base};
        mem[w0 + 11] = mk_lcw(s0, io, cs0, noise);
        mem[w0 + 12] = {t, 24'hD0013};
        mem[w0 + 13] = {t, 24'hD0014};
        for (int i = 0; i < 16; i++) sreg[i] = '1;
        st0 = step_cnt; dn0 = done_cnt;
        test_base = base;
        start = 1'b1; @(negedge clk); start = 1'b0;
        if (busy_starts) begin
            for (int k = 0; k < 4; k++) begin
                repeat (9) @(negedge clk);
                test_base = 16'h0040; start = 1'b1; @(negedge clk); start = 1'b0;
            end
        end
        wait_n = 0;
        while (done_cnt == dn0 && wait_n < 400) begin @(negedge clk); wait_n++; end
        chk(done_cnt != dn0, "R10 done reached", wait_n, 0);
        chk(done == 0, "R10 done one cycle", done, 0);
        repeat (40) @(negedge clk);
        chk(done_cnt - dn0 == 1, "R10 single done, busy start ignored", done_cnt - dn0, 1);
        ok = 1;
        for (int i = 0; i < 11; i++) if (sreg[i] !== {t, 8'(i), base}) ok = 0;
        chk(ok, "R1 R2 scan-in words in order", sreg[10], {t, 8'(10), base});
        chk(mem[32] == {t, 24'hD0013} && mem[33] == {t, 24'hD0014}, "R8 R2 saved words",
            mem[32], {t, 24'hD0013});
        ok = 1;
        for (int k = 0; k < 14; k++) if (mem[64 + k] !== {8'hC3, t, 12'h000, 4'(k)}) ok = 0;
        chk(ok, "R9 register dump", mem[64 + 13], {8'hC3, t, 16'h000D});
        chk(seq_cnt == 3'd7 && cs_addr == 12'h2C0, "R6 stop value and forced entry",
            {seq_cnt, cs_addr}, {3'd7, 12'h2C0});
        chk(supv_flag && !prog_scan_flag && !sup_en_flag, "R4 forced flags",
            {supv_flag, prog_scan_flag, sup_en_flag}, 3'b100);
        chk(io_mode_flag == io, "R3 R4 io mode copy", io_mode_flag, io);
        exp_steps = (cs0 == 0) ? 0 : 7 - int'(s0);
        chk(step_cnt - st0 == exp_steps, "R5 R6 R7 step count", step_cnt - st0, exp_steps);
        ok = 1;
        for (int k = 0; k < exp_steps; k++)
            if (step_log[(st0 + k) % 8] !== cs0 + 12'(3 * k)) ok = 0;
        chk(ok, "R3 R5 step addresses", step_log[st0 % 8], cs0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        test_reset();
        run_test(16'h0000, 3'd5, 12'h123, 1'b1, 1'b0, 8'h11, 1'b0); // two steps
        run_test(16'h0180, 3'd0, 12'h7F0, 1'b0, 1'b1, 8'h22, 1'b1); // seven steps, noise bits, busy starts
        run_test(16'h0140, 3'd7, 12'h055, 1'b1, 1'b1, 8'h33, 1'b0); // R6: counter loaded at seven
        run_test(16'h0000, 3'd2, 12'h000, 1'b0, 1'b0, 8'h44, 1'b0); // R7: zero-cycle test
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule